// File: doc/BRIEF.md
# Prescaled Match Timer with PWM Outputs

A 16-bit up-counter that advances once per prescale period. A programmable prescale counter divides the clock. Four compare channels watch the count. Each channel can raise a sticky interrupt flag, return the count to zero, or halt the timer when the count meets its compare value. A compare takes effect one clock after the count first shows the compare value, so the matching count is held for a full prescale period before it is acted on.

Any channel can instead drive a pulse-width waveform on its output pin. In that mode the highest-numbered channel's compare value sets the period. Software reaches the block through a plain register port: one write strobe, one address, write data and a combinational read-data bus. The port has no valid/ready handshake. Every register write completes in the clock it is presented, and reads return immediately, so there is never any back-pressure.

Top module: `match_timer`

## Requirements
- R1: After reset the count, the prescale count, the control register (address 0), the flag register (address 6) and all outputs read 0.
- R2: While control bit 0 (run) is 1 and control bit 1 (clear) is 0, the prescale counter (address 3) steps 0, 1, …, P, where P is the prescale register (address 1). The count (address 2) then goes up by one, so it advances every P+1 clocks.
- R3: While run is 0, neither the prescale counter nor the count changes.
- R4: With a channel's reset bit set, the count holds that channel's compare value for one whole prescale period and then becomes 0 (compare 6 gives 0..6, 0).
- R5: Flag bit i of address 6 is set one clock after the count newly takes the value of compare register i (address 8+i), not in the same clock.
- R6: With a channel's stop bit set, run is cleared in the same clock as that channel's flag is set. The count then holds and the prescale counter reads 0.
- R7: When one channel requests stop and another requests reset in the same clock, stop wins: the count keeps its value and run is cleared.
- R8: Flags are sticky. Writing 1 to a bit of address 6 clears it, and writing 0 leaves it. The irq pin is the OR of the flags whose enable is set. Address 4 holds three bits per channel i: bit 3i enables the interrupt, bit 3i+1 enables reset and bit 3i+2 enables stop.
- R9: When any bit of the PWM enable register (address 5, bit i for channel i) is set, the count returns to 0 after it has held the value of compare register 3.
- R10: A channel in PWM mode outputs 0 from the start of the cycle. The output goes to 1 one clock after the count reaches the channel's compare value and stays 1 through the clock after the count reaches compare register 3. A compare value equal to or above compare register 3 keeps the output at 0.
- R11: A channel not in PWM mode outputs a one-clock pulse in the same clock its flag is set.
- R12: While clear (control bit 1) is 1, the count and prescale counter are forced to 0 and no channel matches.
- R13: The prescale, compare, channel-control and PWM-enable registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 1 | Enabled-flag interrupt |
| mat_out | output | 4 | Per-channel match pulse or PWM level |

## Verification
The assertions assume that reset is asserted from time zero. They also assume that software never writes the control register in the same clock that a stop match clears run. Under that assumption, the check that a stop clears run excludes control writes rather than ranking them. The prescale-step property assumes the prescale value does not drop below the running prescale count during a period. The stimulus respects all of this: it changes compare values, the prescale value and channel controls only while the timer is stopped or held clear. It issues control writes only after all timed expectations for a run have been consumed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_AW = 4;
  typedef logic [TMR_AW-1:0] tmr_addr_t;

  // register addresses
  localparam tmr_addr_t A_CTRL   = 4'd0;
  localparam tmr_addr_t A_PRESC  = 4'd1;
  localparam tmr_addr_t A_COUNT  = 4'd2;
  localparam tmr_addr_t A_PCOUNT = 4'd3;
  localparam tmr_addr_t A_MCTRL  = 4'd4;
  localparam tmr_addr_t A_PWMEN  = 4'd5;
  localparam tmr_addr_t A_FLAGS  = 4'd6;
  localparam tmr_addr_t A_MATCH0 = 4'd8;

  // control register bits
  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_CLR = 1;

  // per-channel control field: bit0 irq, bit1 reset, bit2 stop
  localparam int unsigned CFG_BITS = 3;
  typedef struct packed {
    logic stop;
    logic rst;
    logic irq;
  } chan_cfg_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           clr,
  input  logic           halt,
  input  logic [PSW-1:0] pr,
  output logic [PSW-1:0] pc,
  output logic           tick
);
  // end of a prescale period; >= keeps a lowered limit from running away
  assign tick = run && !clr && (pc >= pr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc <= '0;
    else if (clr || halt) pc <= '0;
    else if (run)        pc <= tick ? '0 : pc + 1'b1;
  end
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tc,
  input  logic          tc_new,
  input  logic [TW-1:0] mr,
  input  logic [TW-1:0] cyc_len,
  input  logic          pwm_en,
  output logic          eq,
  output logic          evt,
  output logic          out_q
);
  logic level;

  assign eq    = (tc == mr);
  assign evt   = tc_new && eq;            // count has just arrived at mr
  assign level = (mr < cyc_len) && (tc >= mr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= pwm_en ? level : evt;
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import tmr_pkg::*;
#(
  parameter int unsigned TW  = 16,
  parameter int unsigned PSW = 16,
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [TMR_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic [NCH-1:0]    mat_out
);
  localparam int unsigned CYC_CH = NCH - 1;
  localparam int unsigned CFG_W  = NCH * CFG_BITS;

  logic                      run_q, clr_q;
  logic [PSW-1:0]            pr_q, pc;
  chan_cfg_t [NCH-1:0]       cfg_q;
  logic [NCH-1:0]            pwm_q, flags_q;
  logic [TW-1:0]             mr_q [NCH];
  logic [TW-1:0]             tc_q;
  logic                      tc_new_q;
  logic                      tick, stop_evt, rst_hit;
  logic [NCH-1:0]            eq, evt, irq_en, rst_en, stop_en, mr_wr;
  logic                      ctrl_wr, presc_wr, mctrl_wr, pwm_wr, flag_wr;
  logic [NCH-1:0]            flag_clr;

  assign ctrl_wr  = reg_we && (reg_addr == A_CTRL);
  assign presc_wr = reg_we && (reg_addr == A_PRESC);
  assign mctrl_wr = reg_we && (reg_addr == A_MCTRL);
  assign pwm_wr   = reg_we && (reg_addr == A_PWMEN);
  assign flag_wr  = reg_we && (reg_addr == A_FLAGS);
  assign flag_clr = flag_wr ? reg_wdata[NCH-1:0] : '0;

  tmr_prescaler #(.PSW(PSW)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .clr  (clr_q),
    .halt (stop_evt),
    .pr   (pr_q),
    .pc   (pc),
    .tick (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign irq_en[i]  = cfg_q[i].irq;
    assign rst_en[i]  = cfg_q[i].rst;
    assign stop_en[i] = cfg_q[i].stop;
    assign mr_wr[i]   = reg_we && (reg_addr == tmr_addr_t'(A_MATCH0 + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mr_q[i] <= '0;
      else if (mr_wr[i]) mr_q[i] <= reg_wdata[TW-1:0];
    end

    tmr_match_chan #(.TW(TW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .tc     (tc_q),
      .tc_new (tc_new_q && !clr_q),
      .mr     (mr_q[i]),
      .cyc_len(mr_q[CYC_CH]),
      .pwm_en (pwm_q[i]),
      .eq     (eq[i]),
      .evt    (evt[i]),
      .out_q  (mat_out[i])
    );
  end

  assign stop_evt = |(evt & stop_en);
  assign rst_hit  = (|(eq & rst_en)) || ((|pwm_q) && eq[CYC_CH]);
  assign irq      = |(flags_q & irq_en);

  // configuration and control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      clr_q   <= 1'b0;
      pr_q    <= '0;
      cfg_q   <= '0;
      pwm_q   <= '0;
      flags_q <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q <= reg_wdata[CTRL_RUN];
        clr_q <= reg_wdata[CTRL_CLR];
      end else if (stop_evt) begin
        run_q <= 1'b0;
      end
      if (presc_wr) pr_q  <= reg_wdata[PSW-1:0];
      if (mctrl_wr) cfg_q <= reg_wdata[CFG_W-1:0];
      if (pwm_wr)   pwm_q <= reg_wdata[NCH-1:0];
      flags_q <= (flags_q & ~flag_clr) | evt;
    end
  end

  // timer counter: clear, then stop, then prescale tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q     <= '0;
      tc_new_q <= 1'b0;
    end else if (clr_q) begin
      tc_q     <= '0;
      tc_new_q <= 1'b0;
    end else if (stop_evt) begin
      tc_new_q <= 1'b0;
    end else if (tick) begin
      tc_q     <= rst_hit ? '0 : tc_q + 1'b1;
      tc_new_q <= 1'b1;
    end else begin
      tc_new_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTRL_RUN] = run_q;
        reg_rdata[CTRL_CLR] = clr_q;
      end
      A_PRESC:  reg_rdata[PSW-1:0]   = pr_q;
      A_COUNT:  reg_rdata[TW-1:0]    = tc_q;
      A_PCOUNT: reg_rdata[PSW-1:0]   = pc;
      A_MCTRL:  reg_rdata[CFG_W-1:0] = cfg_q;
      A_PWMEN:  reg_rdata[NCH-1:0]   = pwm_q;
      A_FLAGS:  reg_rdata[NCH-1:0]   = flags_q;
      default:  ;
    endcase
    for (int k = 0; k < NCH; k++) begin
      if (reg_addr == tmr_addr_t'(A_MATCH0 + k)) reg_rdata[TW-1:0] = mr_q[k];
    end
  end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int unsigned TW  = 16,
  parameter int unsigned PSW = 16,
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic           clr,
  input logic [PSW-1:0] pc,
  input logic [PSW-1:0] pr,
  input logic [TW-1:0]  tc,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] evt,
  input logic           stop_evt,
  input logic           ctrl_wr,
  input logic           flag_wr
);
  a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> ($stable(tc) && $stable(pc)));

  a_r12_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tc == '0 && pc == '0));

  a_r2_prescale_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !stop_evt && pc < pr) |=> (pc == $past(pc) + 1'b1));

  a_r5_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));

  a_r6_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !ctrl_wr) |=> !run);

  a_r7_stop_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !clr) |=> $stable(tc));

  a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind match_timer match_timer_chk #(.TW(TW), .PSW(PSW), .NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run_q),
  .clr     (clr_q),
  .pc      (pc),
  .pr      (pr_q),
  .tc      (tc_q),
  .flags   (flags_q),
  .evt     (evt),
  .stop_evt(stop_evt),
  .ctrl_wr (ctrl_wr),
  .flag_wr (flag_wr)
);

// File: tb/match_timer_test.sv
module match_timer_test;
  import tmr_pkg::*;

  localparam int CLK_P = 10;
  localparam int K_CNT = 0;
  localparam int K_IRQ = 1;
  localparam int K_MAT = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  tmr_addr_t       reg_addr = A_COUNT;
  logic [15:0]     reg_wdata = '0;
  logic [15:0]     reg_rdata;
  logic            irq;
  logic [3:0]      mat_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int w_at = 0;
  bit done = 1'b0;

  typedef struct {
    int          at;
    int          kind;
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  match_timer uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .mat_out  (mat_out)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  // driver side: register write, returns with w_at = cycle after the write edge
  task automatic wr(tmr_addr_t a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    w_at = cyc + 1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = A_COUNT;
  endtask

  task automatic rd(tmr_addr_t a, logic [15:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #(CLK_P/4);
    chk(tag, reg_rdata, exp);
    @(negedge clk);
    reg_addr = A_COUNT;
  endtask

  // push an expectation, kept ordered by cycle
  task automatic expect_at(int rel, int kind, logic [15:0] v, string tag);
    exp_t e;
    int idx;
    e.at = w_at + rel; e.kind = kind; e.val = v; e.tag = tag;
    idx = q.size();
    for (int k = q.size() - 1; k >= 0 && q[k].at > e.at; k--) idx = k;
    q.insert(idx, e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor side: pop and compare as the design reaches each cycle
  always @(posedge clk) begin
    #(CLK_P/4);
    while (q.size() > 0 && q[0].at <= cyc) begin
      cur = q.pop_front();
      case (cur.kind)
        K_CNT:   chk(cur.tag, reg_rdata, cur.val);
        K_IRQ:   chk(cur.tag, {15'b0, irq}, cur.val);
        default: chk(cur.tag, {12'b0, mat_out}, cur.val);
      endcase
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_COUNT, 16'h0, "R1 count");
    rd(A_PCOUNT, 16'h0, "R1 prescale count");
    rd(A_CTRL, 16'h0, "R1 control");
    rd(A_FLAGS, 16'h0, "R1 flags");
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 outputs", {12'b0, mat_out}, 16'h0);

    // prescale 2, channel 0 compare 6 with irq + reset
    wr(A_PRESC, 16'd2);
    wr(A_MATCH0, 16'd6);
    wr(A_MCTRL, 16'h0003);
    rd(A_PRESC, 16'd2, "R13 prescale readback");
    rd(A_MCTRL, 16'h0003, "R13 channel control readback");
    wr(A_CTRL, 16'h0001);
    expect_at(3,  K_CNT, 16'd1, "R2 first advance after 3 clocks");
    expect_at(5,  K_CNT, 16'd1, "R2 held within period");
    expect_at(6,  K_CNT, 16'd2, "R2 second advance");
    expect_at(17, K_CNT, 16'd5, "R2 count 5");
    expect_at(18, K_CNT, 16'd6, "R4 reaches match");
    expect_at(18, K_IRQ, 16'd0, "R5 no flag in same clock");
    expect_at(19, K_IRQ, 16'd1, "R5 flag one clock later");
    expect_at(19, K_MAT, 16'h1, "R11 match pulse");
    expect_at(20, K_MAT, 16'h0, "R11 pulse one clock");
    expect_at(20, K_CNT, 16'd6, "R4 match held full period");
    expect_at(21, K_CNT, 16'd0, "R4 wraps to zero");
    expect_at(24, K_CNT, 16'd1, "R4 next cycle");
    drain();

    // R3 stopped counter holds
    wr(A_CTRL, 16'h0000);
    @(negedge clk); #(CLK_P/4); v = reg_rdata;
    repeat (8) @(negedge clk);
    #(CLK_P/4);
    chk("R3 count frozen", reg_rdata, v);

    // R8 sticky flags and write-one-to-clear
    rd(A_FLAGS, 16'h000F, "R8 sticky flags");
    wr(A_FLAGS, 16'h0001);
    expect_at(2, K_IRQ, 16'd0, "R8 irq drops after clear");
    drain();
    rd(A_FLAGS, 16'h000E, "R8 only written bit cleared");
    chk("R8 masked flags give no irq", {15'b0, irq}, 16'h0);
    wr(A_FLAGS, 16'h000F);

    // R12 clear forces zero even with run set
    wr(A_CTRL, 16'h0002);
    wr(A_CTRL, 16'h0003);
    repeat (5) @(negedge clk);
    rd(A_COUNT, 16'h0, "R12 count held at zero");
    rd(A_PCOUNT, 16'h0, "R12 prescale held at zero");

    // channel 1 compare 6 with irq + stop
    wr(A_MCTRL, 16'h0028);
    wr(A_MATCH0 + 4'd1, 16'd6);
    wr(A_FLAGS, 16'h000F);
    wr(A_CTRL, 16'h0001);
    expect_at(18, K_CNT, 16'd6, "R6 reaches match");
    expect_at(18, K_IRQ, 16'd0, "R6 no flag yet");
    expect_at(19, K_IRQ, 16'd1, "R6 flag with stop");
    expect_at(19, K_CNT, 16'd6, "R6 count holds");
    expect_at(30, K_CNT, 16'd6, "R6 count still held");
    drain();
    rd(A_CTRL, 16'h0, "R6 run cleared");
    rd(A_PCOUNT, 16'h0, "R6 prescale zero");

    // R7 stop versus reset in the same clock
    wr(A_FLAGS, 16'h000F);
    wr(A_CTRL, 16'h0002);
    wr(A_PRESC, 16'd0);
    wr(A_MATCH0, 16'd3);
    wr(A_MATCH0 + 4'd1, 16'd3);
    wr(A_MCTRL, 16'h002A);
    wr(A_CTRL, 16'h0001);
    expect_at(3, K_CNT, 16'd3, "R7 reaches match");
    expect_at(4, K_CNT, 16'd3, "R7 stop beats reset");
    expect_at(4, K_IRQ, 16'd1, "R7 flag raised");
    expect_at(8, K_CNT, 16'd3, "R7 still held");
    drain();
    rd(A_CTRL, 16'h0, "R7 run cleared");

    // PWM: cycle 10, channel 0 at 4, channel 1 at 7, channel 2 at 10
    wr(A_CTRL, 16'h0002);
    wr(A_FLAGS, 16'h000F);
    wr(A_MCTRL, 16'h0000);
    wr(A_MATCH0, 16'd4);
    wr(A_MATCH0 + 4'd1, 16'd7);
    wr(A_MATCH0 + 4'd2, 16'd10);
    wr(A_MATCH0 + 4'd3, 16'd10);
    wr(A_PWMEN, 16'h0007);
    rd(A_PWMEN, 16'h0007, "R13 pwm enable readback");
    rd(A_MATCH0 + 4'd3, 16'd10, "R13 compare readback");
    wr(A_CTRL, 16'h0001);
    expect_at(4,  K_MAT, 16'h0, "R10 low before match");
    expect_at(5,  K_MAT, 16'h1, "R10 channel 0 high");
    expect_at(5,  K_IRQ, 16'd0, "R8 disabled flags no irq");
    expect_at(8,  K_MAT, 16'h3, "R10 channel 1 high");
    expect_at(10, K_CNT, 16'd10, "R9 reaches cycle length");
    expect_at(11, K_CNT, 16'd0, "R9 cycle restarts");
    expect_at(11, K_MAT, 16'hB, "R10 R11 end of cycle, channel 2 stays low");
    expect_at(12, K_CNT, 16'd1, "R9 second cycle");
    expect_at(12, K_MAT, 16'h0, "R10 low at new cycle");
    expect_at(16, K_MAT, 16'h1, "R10 channel 0 high again");
    expect_at(22, K_MAT, 16'hB, "R11 cycle pulse repeats");
    expect_at(23, K_MAT, 16'h0, "R10 second restart");
    drain();
    wr(A_CTRL, 16'h0000);
    rd(A_FLAGS, 16'h000F, "R8 flags set while masked");
    chk("R8 irq stays low", {15'b0, irq}, 16'h0);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule